// File: doc/BRIEF.md
# Display Controller Interrupt Aggregator

This block gathers single-cycle event pulses from a display raster engine and its frame DMA into a sticky status register. It raises a single interrupt line whenever an event is pending and software has enabled it. Software reaches the block through a small word-indexed register port. That port offers the pending events in two views: all of them, and only the enabled ones. Enables are changed only through write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. After an interrupt is serviced, software writes the end-of-interrupt register. That write drops the line for a cycle, and the line rises again if work is still pending.

Event inputs are a vector indexed by status bit position. The bench drives them as stimulus; neither the engines nor a processor are modelled. Register reads are combinational from the addressed view. Writes, events and the interrupt line all take effect on the rising clock edge.

Top module: `dispirq_agg`

## Requirements
- R1: A synchronous active-low reset clears every status bit, every enable and the interrupt line.
- R2: An event pulse on input bit 0 (frame done), 2 (sync lost), 5 (FIFO underflow), 6 (palette loaded), 8 (buffer 0 ended) or 9 (buffer 1 ended) sets the same bit of the raw status view (word index 0) at the next edge. Pulses on the other input bits are ignored, and those status bits read 0.
- R3: Writing to the raw view (index 0) or the masked view (index 1) clears every status bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFF clears all pending events.
- R4: Writing ones to the enable-set register (index 2) turns on those enables. Only bits 5, 6, 8 and 9 can be enabled, and zero bits have no effect. Reading index 2 returns the enable mask.
- R5: Writing ones to the enable-clear register (index 3) turns those enables off. Reading index 3 also returns the enable mask.
- R6: The masked view (index 1) reads as the raw status ANDed with the enable mask.
- R7: Except in the cycle after an end-of-interrupt write, the interrupt line equals the OR of the masked status bits. It changes together with the status and enable registers.
- R8: A write to the end-of-interrupt register (index 4, data ignored, reads 0) holds the interrupt line low for the following cycle. The line then rises again if any masked bit is still set.
- R9: When an event and a write-one clear of the same bit fall in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 10 | Event pulses, one per status bit position |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (3) | Register word index |
| bus_wdata_i | input | DATA_W (32) | Register write data |
| bus_rdata_o | output | DATA_W (32) | Read data of the addressed register, combinational |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
Events, writes and enable changes show up in the read views one edge after they are driven. The interrupt line is registered from the next-state status and enables, so it moves on that same edge; after an end-of-interrupt write it is due low one edge later and high again one edge after that. The driver changes inputs only at falling edges, so each stimulus occupies exactly one cycle. Every check item carries the read address and the expected data and line level. The monitor compares it a quarter period after the falling edge at which the item was queued, which is after the edge where the result is due and before the next one.

// File: rtl/dispirq_pkg.sv
package dispirq_pkg;
    localparam int STAT_W = 10;
    // status bits that exist: 0, 2, 5, 6, 8, 9
    localparam logic [STAT_W-1:0] STAT_IMPL = 10'h365;
    // status bits that may be enabled onto the interrupt line: 5, 6, 8, 9
    localparam logic [STAT_W-1:0] EN_IMPL = 10'h360;
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_RAW = 3'd0,
        REG_MSK = 3'd1,
        REG_ENS = 3'd2,
        REG_ENC = 3'd3,
        REG_EOI = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic [STAT_W-1:0] bits;
    } vec_st;

    typedef struct packed {
        logic irq;
    } line_st;
endpackage

// File: rtl/dispirq_decode.sv
module dispirq_decode
    import dispirq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [STAT_W-1:0] clr_o,
    output logic [STAT_W-1:0] set_o,
    output logic [STAT_W-1:0] unset_o,
    output logic              eoi_o
);
    logic [STAT_W-1:0] low_bits;
    logic              unused_hi;

    assign low_bits  = bus_wdata_i[STAT_W-1:0];
    assign unused_hi = ^bus_wdata_i[DATA_W-1:STAT_W];

    always_comb begin
        clr_o   = '0;
        set_o   = '0;
        unset_o = '0;
        eoi_o   = 1'b0;
        if (bus_wr_i) begin
            if (bus_addr_i == ADDR_W'(REG_RAW) || bus_addr_i == ADDR_W'(REG_MSK)) begin
                clr_o = low_bits & STAT_IMPL;
            end
            if (bus_addr_i == ADDR_W'(REG_ENS)) begin
                set_o = low_bits & EN_IMPL;
            end
            if (bus_addr_i == ADDR_W'(REG_ENC)) begin
                unset_o = low_bits & EN_IMPL;
            end
            if (bus_addr_i == ADDR_W'(REG_EOI)) begin
                eoi_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dispirq_status.sv
module dispirq_status
    import dispirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] stat_q_o,
    output logic [STAT_W-1:0] stat_d_o
);
    vec_st             s_d, s_q;
    logic [STAT_W-1:0] nxt;
    logic              unused_in;

    assign unused_in = ^((evt_i | clr_i) & ~STAT_IMPL);

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (STAT_IMPL[b]) begin : g_live
            // a new event outranks a clear in the same cycle
            assign nxt[b] = evt_i[b] | (s_q.bits[b] & ~clr_i[b]);
        end else begin : g_tied
            assign nxt[b] = 1'b0;
        end
    end

    always_comb begin
        s_d.bits = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_q_o = s_q.bits;
    assign stat_d_o = s_d.bits;
endmodule

// File: rtl/dispirq_enable.sv
module dispirq_enable
    import dispirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] unset_i,
    output logic [STAT_W-1:0] en_q_o,
    output logic [STAT_W-1:0] en_d_o
);
    vec_st             e_d, e_q;
    logic [STAT_W-1:0] nxt;
    logic              unused_in;

    assign unused_in = ^((set_i | unset_i) & ~EN_IMPL);

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (EN_IMPL[b]) begin : g_live
            assign nxt[b] = set_i[b] | (e_q.bits[b] & ~unset_i[b]);
        end else begin : g_tied
            assign nxt[b] = 1'b0;
        end
    end

    always_comb begin
        e_d.bits = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign en_q_o = e_q.bits;
    assign en_d_o = e_d.bits;
endmodule

// File: rtl/dispirq_agg.sv
module dispirq_agg
    import dispirq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] clr_w, set_w, unset_w;
    logic              eoi_w;
    logic [STAT_W-1:0] stat_q, stat_d, en_q, en_d;
    line_st            l_d, l_q;

    dispirq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .bus_wdata_i(bus_wdata_i),
        .clr_o      (clr_w),
        .set_o      (set_w),
        .unset_o    (unset_w),
        .eoi_o      (eoi_w)
    );

    dispirq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .clr_i   (clr_w),
        .stat_q_o(stat_q),
        .stat_d_o(stat_d)
    );

    dispirq_enable u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .unset_i(unset_w),
        .en_q_o (en_q),
        .en_d_o (en_d)
    );

    // line follows next-state pending work, forced low for one cycle by EOI
    always_comb begin
        l_d.irq = (|(stat_d & en_d)) & ~eoi_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(REG_RAW)) begin
            bus_rdata_o = DATA_W'(stat_q);
        end else if (bus_addr_i == ADDR_W'(REG_MSK)) begin
            bus_rdata_o = DATA_W'(stat_q & en_q);
        end else if (bus_addr_i == ADDR_W'(REG_ENS) || bus_addr_i == ADDR_W'(REG_ENC)) begin
            bus_rdata_o = DATA_W'(en_q);
        end
    end

    assign irq_o = l_q.irq;
endmodule

// File: rtl/dispirq_agg_chk.sv
module dispirq_agg_chk
    import dispirq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] evt_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] en_q,
    input logic              irq_o
);
    logic eoi_hit;
    logic raw_wr;
    logic ens_wr;
    logic enc_wr;

    assign eoi_hit = bus_wr_i && bus_addr_i == ADDR_W'(REG_EOI);
    assign raw_wr  = bus_wr_i && bus_addr_i == ADDR_W'(REG_RAW);
    assign ens_wr  = bus_wr_i && bus_addr_i == ADDR_W'(REG_ENS);
    assign enc_wr  = bus_wr_i && bus_addr_i == ADDR_W'(REG_ENC);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (stat_q == '0 && en_q == '0 && !irq_o));

    // covers R9 as well: a present event always lands
    assert_event_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & STAT_IMPL) != '0) |=>
            ((stat_q & $past(evt_i & STAT_IMPL)) == $past(evt_i & STAT_IMPL)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_wr && (evt_i & bus_wdata_i[STAT_W-1:0]) == '0) |=>
            ((stat_q & $past(bus_wdata_i[STAT_W-1:0])) == '0));

    assert_enable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ens_wr |=> ((en_q & $past(bus_wdata_i[STAT_W-1:0] & EN_IMPL))
                    == $past(bus_wdata_i[STAT_W-1:0] & EN_IMPL)));

    assert_enable_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enc_wr |=> ((en_q & $past(bus_wdata_i[STAT_W-1:0])) == '0));

    assert_line_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(eoi_hit) |-> (irq_o == (|(stat_q & en_q))));

    assert_eoi_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_hit |=> !irq_o);
endmodule

bind dispirq_agg dispirq_agg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .irq_o      (irq_o)
);

// File: tb/dispirq_agg_bench.sv
module dispirq_agg_bench;
    localparam int CLK_PER = 10;
    localparam logic [2:0] A_RAW = 3'd0;
    localparam logic [2:0] A_MSK = 3'd1;
    localparam logic [2:0] A_ENS = 3'd2;
    localparam logic [2:0] A_ENC = 3'd3;
    localparam logic [2:0] A_EOI = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    typedef struct {
        logic [2:0]  a;
        logic [31:0] d;
        logic        i;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PER/2) clk = ~clk;

    dispirq_agg u_dispirq_agg (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .bus_wr_i   (wr),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    // monitor: compares queued expectations a quarter period after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PER/4);
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_chk++;
                if (rdata !== it.d || irq !== it.i) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d rdata 0x%0h irq %b, expected 0x%0h irq %b",
                             it.tag, it.a, rdata, irq, it.d, it.i);
                end
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [9:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [31:0] d, input logic i, input string tag);
        addr = a;
        exp_q.push_back('{a: a, d: d, i: i, tag: tag});
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(A_RAW, 32'h0, 1'b0, "R1 raw after reset");
        chk(A_ENS, 32'h0, 1'b0, "R1 enables after reset");
        chk(A_MSK, 32'h0, 1'b0, "R1 masked after reset");

        pulse(10'h3FF);
        chk(A_RAW, 32'h365, 1'b0, "R2 all inputs pulsed");
        chk(A_MSK, 32'h0, 1'b0, "R6 masked with no enables");

        wr_reg(A_ENS, 32'hFFFF_FFFF);
        chk(A_ENS, 32'h360, 1'b1, "R4 set all enables");
        chk(A_MSK, 32'h360, 1'b1, "R6 masked after enable");

        wr_reg(A_ENC, 32'h100);
        chk(A_ENC, 32'h260, 1'b1, "R5 clear enable bit 8");
        chk(A_MSK, 32'h260, 1'b1, "R6 masked after clear");

        wr_reg(A_RAW, 32'h20);
        chk(A_RAW, 32'h345, 1'b1, "R3 clear bit 5");
        wr_reg(A_RAW, 32'h0);
        chk(A_RAW, 32'h345, 1'b1, "R3 zero write no effect");
        wr_reg(A_MSK, 32'h200);
        chk(A_RAW, 32'h145, 1'b1, "R3 clear via masked view");

        wr_reg(A_EOI, 32'h0);
        chk(A_RAW, 32'h145, 1'b0, "R8 line low after eoi");
        chk(A_MSK, 32'h040, 1'b1, "R8 line back after eoi");

        // R9: event and clear of bit 6 in one cycle
        evt = 10'h040; addr = A_RAW; wdata = 32'h40; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; evt = '0; wdata = '0;
        chk(A_RAW, 32'h145, 1'b1, "R9 event beats clear");

        wr_reg(A_RAW, 32'hFFFF);
        chk(A_RAW, 32'h0, 1'b0, "R3 clear all");
        chk(A_MSK, 32'h0, 1'b0, "R7 line low when nothing pending");

        wr_reg(A_ENS, 32'h0);
        chk(A_ENS, 32'h260, 1'b0, "R4 zero set no effect");

        pulse(10'h100);
        chk(A_RAW, 32'h100, 1'b0, "R7 disabled event keeps line low");
        chk(A_MSK, 32'h0, 1'b0, "R6 disabled event masked out");

        pulse(10'h09A);
        chk(A_RAW, 32'h100, 1'b0, "R2 absent bits ignored");

        wr_reg(A_ENS, 32'h100);
        chk(A_MSK, 32'h100, 1'b1, "R7 line rises on late enable");

        wr_reg(A_ENC, 32'hFFFF_FFFF);
        chk(A_ENS, 32'h0, 1'b0, "R5 clear all enables");

        wr_reg(A_EOI, 32'h0);
        chk(A_EOI, 32'h0, 1'b0, "R8 eoi reads zero");
        chk(A_RAW, 32'h100, 1'b0, "R8 no rise without enabled work");

        @(negedge clk);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end
endmodule